// File: doc/BRIEF.md
# Wave Memory Access Coalescer

This block takes the byte addresses issued by all 64 lanes of one wave, together with one access width shared by every lane. It works out the smallest set of aligned 64-byte line transactions that covers every byte requested. A lane whose request crosses a line boundary counts toward both lines it touches. Each distinct line is counted once, however many lanes hit it.

The whole address vector is accepted in one cycle under a valid/ready start handshake. The block then streams the distinct line indices out in ascending order on a valid/ready output. After the last line has been accepted, it raises a one-cycle done pulse. The pulse carries three totals: the transaction count, the useful byte count and the fetched byte count, so a consumer can work out coalescing efficiency.

Fetching memory, returning data and scattering data back to the lanes are left to neighbouring logic.

Top module: `wave_coalescer`

## Requirements
- R1: After reset, `start_ready_o` is 1, and `line_valid_o` and `done_o` are 0.
- R2: `width_code_i` sets the per-lane access size: 0 selects 4 bytes, 1 selects 8 bytes, and 2 or 3 select 16 bytes. On the done pulse, `useful_bytes_o` equals 64 times that size.
- R3: A lane at byte address a with size w touches the line indices floor(a/64) through floor((a+w-1)/64). A request that straddles a line boundary therefore contributes both lines.
- R4: Each distinct line touched by the wave appears on the output stream exactly once.
- R5: Line indices leave in strictly ascending order within a wave.
- R6: While `line_valid_o` is 1 and `line_ready_i` is 0, the next cycle keeps `line_valid_o` at 1 and `line_idx_o` unchanged.
- R7: In the cycle after the last line handshake, `done_o` is 1 for exactly one cycle. In that cycle `txn_count_o` equals the number of lines emitted and `fetched_bytes_o` equals 64 times that count. `start_ready_o` returns to 1 in the following cycle.
- R8: A wave is captured only on a cycle where both `start_valid_i` and `start_ready_o` are 1. `start_ready_o` stays 0 from capture until the done cycle has passed, and address or width changes during that time have no effect on the wave in flight.
- R9: 64 lanes of 16 contiguous bytes from address 0 give 16 transactions with useful bytes equal to fetched bytes. 64 lanes of 4 bytes at a 256-byte stride give 64 transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | A wave's addresses are offered |
| start_ready_o | output | 1 | Block is idle and can capture a wave |
| width_code_i | input | 2 | Per-lane access size code (see R2) |
| lane_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane n in bits [n*ADDR_W +: ADDR_W] |
| line_valid_o | output | 1 | A line index is presented |
| line_ready_i | input | 1 | Consumer takes the presented line |
| line_idx_o | output | ADDR_W-6 | Line index (address divided by 64) |
| done_o | output | 1 | One-cycle end-of-wave pulse |
| txn_count_o | output | clog2(2*LANES+1) | Transactions in the wave, valid with done |
| useful_bytes_o | output | clog2(16*LANES+1) | Bytes requested by the lanes, valid with done |
| fetched_bytes_o | output | clog2(128*LANES+1) | Bytes fetched by the line transactions, valid with done |

## Verification
The sweep crosses every width code with strides of zero, sub-line, odd, line-sized and larger values. Bases are chosen so that requests straddle line boundaries. A design that dropped the second line of a split request would come up short on the count. One that deduplicated poorly would repeat a line or break ascending order. Random consumer stalls expose a line index that moves while it is held. Holding the start request with different addresses while a wave is being processed exposes a design that captures a second wave in the middle of a scan. The two reference shapes, contiguous 16-byte and 256-byte-stride 4-byte, are checked against fixed transaction counts.

// File: rtl/wc_pkg.sv
package wc_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } wc_phase_e;

    // Size in bytes of one lane access for a width code.
    function automatic logic [4:0] access_bytes(input logic [1:0] code);
        case (code)
            2'd0:    access_bytes = 5'd4;
            2'd1:    access_bytes = 5'd8;
            default: access_bytes = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/wc_lane_split.sv
// Computes the first and last line touched by one lane's access.
module wc_lane_split #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 6,
    localparam int LINE_W    = ADDR_W - LINE_SHIFT
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        code_i,
    output logic [LINE_W-1:0] first_o,
    output logic [LINE_W-1:0] last_o
);
    logic [4:0]        size;
    logic [ADDR_W-1:0] end_addr;

    always_comb begin
        size     = wc_pkg::access_bytes(code_i);
        end_addr = addr_i + ADDR_W'(size - 5'd1);
        first_o  = addr_i[ADDR_W-1:LINE_SHIFT];
        last_o   = end_addr[ADDR_W-1:LINE_SHIFT];
    end
endmodule

// File: rtl/wc_min_finder.sv
// Smallest candidate strictly above a floor (or smallest overall when the
// floor is disabled). Repeated values collapse naturally.
module wc_min_finder #(
    parameter int N = 128,
    parameter int W = 26
) (
    input  logic [W-1:0] cand_i [N],
    input  logic         floor_en_i,
    input  logic [W-1:0] floor_i,
    output logic         found_o,
    output logic [W-1:0] min_o
);
    always_comb begin
        found_o = 1'b0;
        min_o   = '1;
        for (int i = 0; i < N; i++) begin
            if ((!floor_en_i || (cand_i[i] > floor_i)) &&
                (!found_o || (cand_i[i] < min_o))) begin
                found_o = 1'b1;
                min_o   = cand_i[i];
            end
        end
    end
endmodule

// File: rtl/wave_coalescer.sv
module wave_coalescer #(
    parameter int LANES       = 64,
    parameter int ADDR_W      = 32,
    parameter int LINE_SHIFT  = 6,
    localparam int LINE_W     = ADDR_W - LINE_SHIFT,
    localparam int NCAND      = 2 * LANES,
    localparam int CNT_W      = $clog2(NCAND + 1),
    localparam int USE_W      = $clog2(LANES * 16 + 1),
    localparam int FET_W      = $clog2(NCAND * (1 << LINE_SHIFT) + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_valid_i,
    output logic                    start_ready_o,
    input  logic [1:0]              width_code_i,
    input  logic [LANES*ADDR_W-1:0] lane_addr_i,
    output logic                    line_valid_o,
    input  logic                    line_ready_i,
    output logic [LINE_W-1:0]       line_idx_o,
    output logic                    done_o,
    output logic [CNT_W-1:0]        txn_count_o,
    output logic [USE_W-1:0]        useful_bytes_o,
    output logic [FET_W-1:0]        fetched_bytes_o
);
    import wc_pkg::*;

    typedef struct packed {
        wc_phase_e         phase;
        logic              have_last;
        logic [LINE_W-1:0] last;
        logic [CNT_W-1:0]  count;
        logic [1:0]        code;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [LINE_W-1:0] cand_d [NCAND];
    logic [LINE_W-1:0] cand_q [NCAND];

    logic [LINE_W-1:0] first_w [LANES];
    logic [LINE_W-1:0] last_w  [LANES];
    logic              found;
    logic [LINE_W-1:0] min_line;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wc_lane_split #(
            .ADDR_W     (ADDR_W),
            .LINE_SHIFT (LINE_SHIFT)
        ) u_split (
            .addr_i  (lane_addr_i[g*ADDR_W +: ADDR_W]),
            .code_i  (width_code_i),
            .first_o (first_w[g]),
            .last_o  (last_w[g])
        );
    end

    wc_min_finder #(
        .N (NCAND),
        .W (LINE_W)
    ) u_find (
        .cand_i     (cand_q),
        .floor_en_i (ctrl_q.have_last),
        .floor_i    (ctrl_q.last),
        .found_o    (found),
        .min_o      (min_line)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        cand_d = cand_q;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (start_valid_i) begin
                    for (int i = 0; i < LANES; i++) begin
                        cand_d[2*i]   = first_w[i];
                        cand_d[2*i+1] = last_w[i];
                    end
                    ctrl_d.code      = width_code_i;
                    ctrl_d.have_last = 1'b0;
                    ctrl_d.last      = '0;
                    ctrl_d.count     = '0;
                    ctrl_d.phase     = PH_SCAN;
                end
            end
            PH_SCAN: begin
                if (found) begin
                    if (line_ready_i) begin
                        ctrl_d.last      = min_line;
                        ctrl_d.have_last = 1'b1;
                        ctrl_d.count     = ctrl_q.count + CNT_W'(1);
                    end
                end else begin
                    ctrl_d.phase = PH_IDLE;
                end
            end
            default: ctrl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{phase: PH_IDLE, have_last: 1'b0, last: '0, count: '0, code: 2'd0};
            for (int i = 0; i < NCAND; i++) cand_q[i] <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cand_q <= cand_d;
        end
    end

    always_comb begin
        start_ready_o   = (ctrl_q.phase == PH_IDLE);
        line_valid_o    = (ctrl_q.phase == PH_SCAN) && found;
        line_idx_o      = min_line;
        done_o          = (ctrl_q.phase == PH_SCAN) && !found;
        txn_count_o     = ctrl_q.count;
        useful_bytes_o  = USE_W'(LANES) * USE_W'(access_bytes(ctrl_q.code));
        fetched_bytes_o = FET_W'(ctrl_q.count) << LINE_SHIFT;
    end
endmodule

// File: rtl/wave_coalescer_checker.sv
module wave_coalescer_checker #(
    parameter int LANES  = 64,
    parameter int LINE_W = 26,
    parameter int CNT_W  = 8,
    parameter int USE_W  = 11
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_valid_i,
    input logic              start_ready_o,
    input logic              line_valid_o,
    input logic              line_ready_i,
    input logic [LINE_W-1:0] line_idx_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  txn_count_o,
    input logic [USE_W-1:0]  useful_bytes_o
);
    logic              seen_q;
    logic [LINE_W-1:0] prev_q;
    logic [CNT_W-1:0]  hs_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
            prev_q <= '0;
            hs_q   <= '0;
        end else if (start_valid_i && start_ready_o) begin
            seen_q <= 1'b0;
            hs_q   <= '0;
        end else if (line_valid_o && line_ready_i) begin
            seen_q <= 1'b1;
            prev_q <= line_idx_o;
            hs_q   <= hs_q + CNT_W'(1);
        end
    end

    assert_hold_while_stalled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_valid_o && !line_ready_i) |=> (line_valid_o && $stable(line_idx_o)));

    assert_strictly_ascending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_valid_o && line_ready_i && seen_q) |-> (line_idx_o > prev_q));

    assert_count_matches_stream_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (txn_count_o == hs_q));

    assert_done_returns_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (start_ready_o && !done_o));

    assert_busy_excludes_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_ready_o |-> (!line_valid_o && !done_o));

    assert_useful_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((useful_bytes_o == USE_W'(LANES * 4)) ||
                    (useful_bytes_o == USE_W'(LANES * 8)) ||
                    (useful_bytes_o == USE_W'(LANES * 16))));
endmodule

bind wave_coalescer wave_coalescer_checker #(
    .LANES  (LANES),
    .LINE_W (LINE_W),
    .CNT_W  (CNT_W),
    .USE_W  (USE_W)
) u_checker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_valid_i  (start_valid_i),
    .start_ready_o  (start_ready_o),
    .line_valid_o   (line_valid_o),
    .line_ready_i   (line_ready_i),
    .line_idx_o     (line_idx_o),
    .done_o         (done_o),
    .txn_count_o    (txn_count_o),
    .useful_bytes_o (useful_bytes_o)
);

// File: tb/wave_coalescer_bench.sv
module wave_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 64;
    localparam int ADDR_W = 32;
    localparam int LINE_W = ADDR_W - 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_valid = 1'b0;
    logic                    start_ready;
    logic [1:0]              width_code = 2'd0;
    logic [LANES*ADDR_W-1:0] addrs = '0;
    logic                    line_valid;
    logic                    line_ready = 1'b0;
    logic [LINE_W-1:0]       line_idx;
    logic                    done;
    logic [7:0]              txn_count;
    logic [10:0]             useful_bytes;
    logic [13:0]             fetched_bytes;

    int checks = 0;
    int errors = 0;
    int last_txn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_wave_coalescer (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .start_valid_i   (start_valid),
        .start_ready_o   (start_ready),
        .width_code_i    (width_code),
        .lane_addr_i     (addrs),
        .line_valid_o    (line_valid),
        .line_ready_i    (line_ready),
        .line_idx_o      (line_idx),
        .done_o          (done),
        .txn_count_o     (txn_count),
        .useful_bytes_o  (useful_bytes),
        .fetched_bytes_o (fetched_bytes)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one wave: lane n at base + n*stride. Expected lines are derived
    // from R3 (floor(a/64) .. floor((a+w-1)/64)), sorted and made unique.
    task automatic run_wave(input int base, input int stride, input int code,
                            input bit stall, input bit noise);
        int exp_lines [128];
        int n = 0;
        int size;
        int got = 0;
        int cyc = 0;
        bit held = 1'b0;
        int held_line = 0;
        size = (code == 0) ? 4 : (code == 1) ? 8 : 16;
        for (int lane = 0; lane < LANES; lane++) begin
            int a = base + lane * stride;
            int lines [2];
            lines[0] = a / 64;
            lines[1] = (a + size - 1) / 64;
            for (int k = 0; k < 2; k++) begin
                bit dup = 1'b0;
                for (int j = 0; j < n; j++) if (exp_lines[j] == lines[k]) dup = 1'b1;
                if (!dup) begin
                    exp_lines[n] = lines[k];
                    n++;
                end
            end
        end
        for (int i = 1; i < n; i++) begin
            int v = exp_lines[i];
            int j = i - 1;
            while (j >= 0 && exp_lines[j] > v) begin
                exp_lines[j+1] = exp_lines[j];
                j--;
            end
            exp_lines[j+1] = v;
        end

        @(negedge clk);
        for (int lane = 0; lane < LANES; lane++)
            addrs[lane*ADDR_W +: ADDR_W] = ADDR_W'(base + lane * stride);
        width_code  = 2'(code);
        start_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (noise) begin
            // R8: a changed request held during the scan must be ignored
            for (int lane = 0; lane < LANES; lane++)
                addrs[lane*ADDR_W +: ADDR_W] = ADDR_W'(32'h4_0000 + lane * 1000);
            width_code = 2'(~code);
        end else begin
            start_valid = 1'b0;
        end
        check(start_ready == 1'b0, "R8 ready low while busy", start_ready, 0);

        forever begin
            line_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (held)
                check(line_valid && (int'(line_idx) == held_line), "R6 held line",
                      line_idx, held_line);
            if (done) begin
                check(int'(txn_count) == n, "R4 transaction count", txn_count, n);
                check(got == n, "R4 lines streamed", got, n);
                check(int'(useful_bytes) == 64 * size, "R2 useful bytes",
                      useful_bytes, 64 * size);
                check(int'(fetched_bytes) == 64 * n, "R7 fetched bytes",
                      fetched_bytes, 64 * n);
                last_txn = n;
                break;
            end
            if (line_valid) begin
                if (line_ready) begin
                    // R3 line derivation, R4 uniqueness and R5 order together
                    if (got < n)
                        check(int'(line_idx) == exp_lines[got], "R5 line value/order",
                              line_idx, exp_lines[got]);
                    else
                        check(1'b0, "R4 extra line", line_idx, -1);
                    got++;
                    held = 1'b0;
                end else begin
                    held      = 1'b1;
                    held_line = int'(line_idx);
                end
            end else begin
                held = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start_valid = 1'b0;
        line_ready  = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", done, 0);
        check(start_ready == 1'b1, "R7 ready after done", start_ready, 1);
    endtask

    initial begin
        int strides [8] = '{0, 4, 8, 16, 20, 64, 100, 256};
        int bases   [4] = '{0, 60, 61, 126};
        int idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(start_ready == 1'b1, "R1 ready in reset", start_ready, 1);
        check(line_valid == 1'b0, "R1 no line in reset", line_valid, 0);
        check(done == 1'b0, "R1 no done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_ready == 1'b1 && !line_valid && !done, "R1 idle after reset",
              start_ready, 1);

        // R9 reference shapes
        run_wave(0, 16, 2, 1'b0, 1'b0);
        check(last_txn == 16, "R9 contiguous 16B count", last_txn, 16);
        run_wave(0, 256, 0, 1'b1, 1'b0);
        check(last_txn == 64, "R9 stride 256 count", last_txn, 64);

        // Sweep: width codes x strides x bases, with stalls and start noise
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 8; s++)
                for (int b = 0; b < 4; b++) begin
                    run_wave(bases[b], strides[s], c, idx[0], (idx % 5) == 0);
                    idx++;
                end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule